// File: doc/BRIEF.md
# Prioritized Interrupt Status Controller

This block gathers seven level-sensitive interrupt request lines from a backplane bus and runs an acknowledge handshake for each one the host has enabled. When more than one enabled line is waiting, the highest level goes first. The handshake reports back an 8-bit vector or an error. The block stores that result in a per-level result register, then sets the level's bit in a 24-bit status register. One host interrupt line is driven high whenever a status bit and its enable bit are both set.

The host reaches the block through a single-cycle register port. The status register is write-one-to-clear. The enable register is a plain read/write mask. Each level's result register is read-only. The bus acknowledge cycle is reduced to a request/response handshake: the block presents a level number, and the responder later returns a vector or an error. Only one acknowledge is in flight at any time. A level is not acknowledged again while its status bit is still set.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status register, the enable register and all seven result registers read zero, and both `irq_o` and `ack_req_o` are low.
- R2: Interrupt level n (1..7), which arrives on `irq_req_i[n-1]`, owns status bit n. Status bit 0 and bits 23:8 are placeholder bits: hardware never sets them and they read zero.
- R3: Writing the status register clears each bit written as 1. Bits written as 0 keep their value.
- R4: A level is acknowledged only while its request line is high and its enable bit (bit n of the enable register) is set. Enabling levels 1 to 7 uses mask 0xFE.
- R5: When several levels qualify at the same time, they are acknowledged one after another from the highest level to the lowest.
- R6: `ack_req_o` stays high with a stable, nonzero `ack_lvl_o` (the 3-bit level number) until the cycle in which `ack_rsp_i` is high. Only one acknowledge is outstanding at a time.
- R7: When an acknowledge completes, the result register of that level takes the value {error, vector}. Bit 8 is `ack_err_i`. Bits 7:0 are `ack_vec_i`, or zero if an error was returned.
- R8: A level's status bit is set in the cycle after its response. A level whose status bit is set is not acknowledged again until the host clears the bit.
- R9: `irq_o` is high exactly when the bitwise AND of status and enable is nonzero.
- R10: Register word addresses are 0 for status, 1 for enable, and n+1 for the result register of level n. Writes to result registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| irq_req_i | input | 7 | Bus request lines; bit k is level k+1 |
| ack_req_o | output | 1 | Acknowledge request outstanding |
| ack_lvl_o | output | 3 | Level being acknowledged |
| ack_rsp_i | input | 1 | Acknowledge response valid, one cycle |
| ack_err_i | input | 1 | Response ended in a bus error |
| ack_vec_i | input | 8 | Returned vector |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 24 | Register write data |
| reg_rdata_o | output | 24 | Register read data, combinational from address |
| irq_o | output | 1 | Host interrupt |

## Verification
A single enabled level shows the basic acknowledge and status-set path. Three simultaneous levels (3, 5, 7) show the descending service order, because each level returns a different vector. A request on a masked level, and a request held high while its status bit is still set, show that the enable mask gates acknowledges and that a level is not serviced twice. An error response, a delayed response, and status writes that mix ones and zeros separate the error-flag path, the handshake hold behaviour and write-one-to-clear from plain overwrite.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NLEVEL = 7;
  localparam int STAT_W = 24;
  localparam int VEC_W  = 8;
  localparam int LVL_W  = $clog2(NLEVEL + 1);
  localparam int SID_W  = VEC_W + 1;
  localparam int ADDR_W = $clog2(NLEVEL + 2);

  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_EN   = ADDR_W'(1);
  localparam int                SID_OFS   = 1;  // level n at word n+1

  typedef enum logic {ACK_IDLE, ACK_WAIT} ack_state_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NLEVEL = irq_pkg::NLEVEL,
  parameter int LVL_W  = irq_pkg::LVL_W
) (
  input  logic [NLEVEL-1:0] cand_i,
  output logic              found_o,
  output logic [LVL_W-1:0]  lvl_o
);
  // ascending scan: the last hit, the highest level, wins
  always_comb begin
    found_o = 1'b0;
    lvl_o   = '0;
    for (int k = 0; k < NLEVEL; k++) begin
      if (cand_i[k]) begin
        found_o = 1'b1;
        lvl_o   = LVL_W'(k + 1);
      end
    end
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          found_i,
  input  logic [LW-1:0] lvl_i,
  input  logic          ack_rsp_i,
  output logic          ack_req_o,
  output logic [LW-1:0] ack_lvl_o,
  output logic          done_o
);
  ack_state_e    state_q, state_n;
  logic [LW-1:0] lvl_q, lvl_n;
  logic          lvl_en;

  always_comb begin
    state_n = state_q;
    lvl_n   = lvl_q;
    lvl_en  = 1'b0;
    unique case (state_q)
      ACK_IDLE: if (found_i) begin
        state_n = ACK_WAIT;
        lvl_n   = lvl_i;
        lvl_en  = 1'b1;
      end
      ACK_WAIT: if (ack_rsp_i) state_n = ACK_IDLE;
      default:  state_n = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACK_IDLE;
      lvl_q   <= '0;
    end else begin
      state_q <= state_n;
      if (lvl_en) lvl_q <= lvl_n;
    end
  end

  assign ack_req_o = (state_q == ACK_WAIT);
  assign ack_lvl_o = lvl_q;
  assign done_o    = ack_req_o && ack_rsp_i;

  // R6
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_o && !ack_rsp_i) |=> (ack_req_o && $stable(ack_lvl_o)));
  // R6
  ack_lvl_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |-> (ack_lvl_o != '0));
endmodule

// File: rtl/irq_csr.sv
module irq_csr
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] rdata_o,
  input  logic              done_i,
  input  logic [LVL_W-1:0]  done_lvl_i,
  input  logic              err_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] enable_o
);
  localparam logic [STAT_W-1:0] LVL_MASK = STAT_W'(((1 << NLEVEL) - 1) << 1);

  logic [STAT_W-1:0] status_q, status_n, enable_q;
  logic              stat_wr, en_wr;
  logic [SID_W-1:0]  sid_q [1:NLEVEL];
  logic [SID_W-1:0]  sid_new;

  assign stat_wr = wr_i && (addr_i == ADDR_STAT);
  assign en_wr   = wr_i && (addr_i == ADDR_EN);
  assign sid_new = {err_i, err_i ? {VEC_W{1'b0}} : vec_i};

  always_comb begin
    status_n = status_q & ~(stat_wr ? wdata_i : '0);
    if (done_i) status_n[done_lvl_i] = 1'b1;
    status_n = status_n & LVL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_n;
      if (en_wr) enable_q <= wdata_i;
    end
  end

  for (genvar g = 1; g <= NLEVEL; g++) begin : g_sid
    logic sid_en;
    assign sid_en = done_i && (done_lvl_i == LVL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sid_q[g] <= '0;
      else if (sid_en) sid_q[g] <= sid_new;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_STAT) rdata_o = status_q;
    if (addr_i == ADDR_EN)   rdata_o = enable_q;
    for (int n = 1; n <= NLEVEL; n++) begin
      if (addr_i == ADDR_W'(n + SID_OFS)) rdata_o = STAT_W'(sid_q[n]);
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !done_i) |=> ((status_q & $past(wdata_i)) == '0));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLEVEL-1:0] irq_req_i,
  output logic              ack_req_o,
  output logic [LVL_W-1:0]  ack_lvl_o,
  input  logic              ack_rsp_i,
  input  logic              ack_err_i,
  input  logic [VEC_W-1:0]  ack_vec_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [STAT_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] status, enable;
  logic [NLEVEL-1:0] cand;
  logic              found, done;
  logic [LVL_W-1:0]  pick_lvl;

  // a level qualifies if requested, enabled and not already reported
  for (genvar k = 0; k < NLEVEL; k++) begin : g_cand
    assign cand[k] = irq_req_i[k] & enable[k+1] & ~status[k+1];
  end

  irq_prio_pick #(.NLEVEL(NLEVEL), .LVL_W(LVL_W)) u_pick (
    .cand_i (cand),
    .found_o(found),
    .lvl_o  (pick_lvl)
  );

  irq_ack_seq #(.LW(LVL_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .found_i  (found),
    .lvl_i    (pick_lvl),
    .ack_rsp_i(ack_rsp_i),
    .ack_req_o(ack_req_o),
    .ack_lvl_o(ack_lvl_o),
    .done_o   (done)
  );

  irq_csr u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .done_i    (done),
    .done_lvl_i(ack_lvl_o),
    .err_i     (ack_err_i),
    .vec_i     (ack_vec_i),
    .status_o  (status),
    .enable_o  (enable)
  );

  assign irq_o = |(status & enable);

  // R8
  no_reack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req_o) |-> !status[ack_lvl_o]);
endmodule

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  irq_req;
  logic        ack_req, ack_rsp, ack_err, irq;
  logic [2:0]  ack_lvl;
  logic [7:0]  ack_vec;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [23:0] reg_wdata, reg_rdata;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req),
    .ack_req_o(ack_req), .ack_lvl_o(ack_lvl), .ack_rsp_i(ack_rsp),
    .ack_err_i(ack_err), .ack_vec_i(ack_vec), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [23:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [23:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic respond(input logic [2:0] lvl, input logic [7:0] v, input logic e, input int hold, input string tag);
    int w = 0;
    while (!ack_req && w < 50) begin @(negedge clk); w++; end
    chk(ack_req == 1'b1, {tag, " ack_req"}, 32'(ack_req), 1);
    chk(ack_lvl == lvl, {tag, " ack_lvl"}, 32'(ack_lvl), 32'(lvl));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(ack_req && ack_lvl == lvl, "R6 hold", 32'(ack_lvl), 32'(lvl));
    end
    ack_rsp = 1'b1; ack_vec = v; ack_err = e;
    @(negedge clk);
    ack_rsp = 1'b0; ack_err = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk(4'd0, 24'h0, "R1 status");
    rd_chk(4'd1, 24'h0, "R1 enable");
    for (int n = 1; n <= 7; n++) rd_chk(4'(n + 1), 24'h0, "R1 result reg");
    chk(!irq && !ack_req, "R1 outputs", {30'b0, irq, ack_req}, 0);
  endtask

  task automatic t_mask;
    irq_req = 7'b000_1000;           // level 4
    repeat (10) @(negedge clk);
    chk(!ack_req, "R4 masked no ack", 32'(ack_req), 0);
    wr(4'd1, 24'h04);                // only level 2 enabled
    repeat (10) @(negedge clk);
    chk(!ack_req, "R4 other level enabled", 32'(ack_req), 0);
    rd_chk(4'd0, 24'h0, "R4 status untouched");
    irq_req = '0;
    wr(4'd1, 24'h0);
  endtask

  task automatic t_single;
    irq_req = 7'b000_1000;
    wr(4'd1, 24'hFE);
    respond(3'd4, 8'h5A, 1'b0, 3, "R4 single");
    rd_chk(4'd0, 24'h10, "R2 R8 status bit 4");
    rd_chk(4'd5, 24'h05A, "R7 vector level 4");
    chk(irq, "R9 irq high", 32'(irq), 1);
    repeat (10) @(negedge clk);
    chk(!ack_req, "R8 no re-ack while set", 32'(ack_req), 0);
  endtask

  task automatic t_w1c;
    wr(4'd0, 24'hFFFFEF);
    rd_chk(4'd0, 24'h10, "R3 zero keeps bit");
    wr(4'd5, 24'h1FF);
    rd_chk(4'd5, 24'h05A, "R10 result reg read-only");
    wr(4'd0, 24'h10);
    rd_chk(4'd0, 24'h0, "R3 one clears bit");
    chk(!irq, "R9 irq low after clear", 32'(irq), 0);
    respond(3'd4, 8'h33, 1'b0, 0, "R8 re-ack after clear");
    rd_chk(4'd5, 24'h033, "R7 new vector");
    irq_req = '0;
    wr(4'd0, 24'hFFFFFF);
    rd_chk(4'd0, 24'h0, "R3 clear all");
  endtask

  task automatic t_prio;
    irq_req = 7'b101_0100;           // levels 7, 5, 3
    respond(3'd7, 8'h71, 1'b0, 0, "R5 first");
    respond(3'd5, 8'h52, 1'b0, 0, "R5 second");
    respond(3'd3, 8'h33, 1'b0, 0, "R5 third");
    irq_req = '0;
    rd_chk(4'd0, 24'hA8, "R2 R5 status");
    rd_chk(4'd8, 24'h071, "R7 level 7");
    rd_chk(4'd6, 24'h052, "R7 level 5");
    rd_chk(4'd4, 24'h033, "R7 level 3");
    wr(4'd0, 24'hA8);
  endtask

  task automatic t_err;
    irq_req = 7'b000_0001;           // level 1
    respond(3'd1, 8'hEE, 1'b1, 0, "R7 error");
    irq_req = '0;
    rd_chk(4'd2, 24'h100, "R7 error flag");
    rd_chk(4'd0, 24'h02, "R2 status bit 1");
    wr(4'd1, 24'hFC);
    chk(!irq, "R9 masked status", 32'(irq), 0);
    rd_chk(4'd0, 24'h02, "R9 status kept");
    wr(4'd1, 24'hFFFFFF);
    chk(irq, "R9 unmasked", 32'(irq), 1);
    rd_chk(4'd0, 24'h02, "R2 placeholders zero");
  endtask

  initial begin
    rst_n = 1'b0; irq_req = '0; ack_rsp = 0; ack_err = 0; ack_vec = '0;
    reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_single();
    t_w1c();
    t_prio();
    t_err();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule